// File: doc/BRIEF.md
# DDR Burst Column Address Generator

This block produces the column address of every data beat in a double-data-rate read or write burst. A mode write loads three settings from the address bus and stores them: the burst length (2, 4 or 8 beats), the wrap order (sequential or interleaved) and the CAS latency (2 or 2.5 clocks). A start pulse then supplies the first column address. Data moves on both clock edges, so the block emits two beat addresses each clock cycle. One address is for the rising-edge beat and one is for the falling-edge beat. The pairs continue until the burst is complete.

A flag marks the clock that carries the final beat. A one-cycle done pulse follows it, and the block then returns to idle. The stored CAS latency is presented in half-clock units for the read-data timing logic downstream. Settings cannot change in the middle of a burst. A mode write that arrives during a burst is refused and reported on an error flag. A mode write that carries an unsupported code is refused in the same way.

Top module: `burst_col_gen`

## Requirements
- R1: After reset the block is idle, with `beatValid`, `lastBeat`, `burstDone`, `busy` and `mrsError` low. The settings after reset are burst length 2, sequential order and CAS latency 2, so `cfgLatHalf` is 4.
- R2: A mode write (`mrsValid` high) that is sampled while idle with a supported code is accepted. The code fields are: `mrsAddr[2:0]` selects the length (1 for 2 beats, 2 for 4 beats, 3 for 8 beats); `mrsAddr[3]` selects the order (0 for sequential, 1 for interleaved); `mrsAddr[6:4]` selects the latency (3'b010 for 2 clocks, 3'b110 for 2.5 clocks). In the following cycle `cfgLatHalf` reads 4 or 5, and every later burst uses the new settings.
- R3: A start pulse sampled while idle begins a burst. From the next cycle on, `beatValid` and `busy` are high for exactly BL/2 cycles. In the cycle at offset k, `beatAddrRise` carries beat 2k and `beatAddrFall` carries beat 2k+1.
- R4: In sequential order, beat n keeps the bits of the start column above log2(BL) unchanged. Its low log2(BL) bits equal the start value's low bits plus n, modulo BL.
- R5: In interleaved order, beat n is the start column with its low log2(BL) bits XORed with n.
- R6: `lastBeat` is high in the final pair cycle of a burst and only in that cycle.
- R7: In the cycle after the final pair, `burstDone` is high for exactly one cycle while `beatValid` and `busy` are low. A start pulse sampled in that cycle begins a new burst.
- R8: A start pulse sampled during a burst is ignored, and the burst in progress continues with its original addresses and length.
- R9: A mode write sampled during a burst is refused. `mrsError` is high in the following cycle, and the stored settings, including `cfgLatHalf`, are unchanged.
- R10: A mode write sampled while idle with an unsupported length code (0 or 4 to 7) or an unsupported latency code is refused. `mrsError` is high in the following cycle, and the settings are unchanged.
- R11: A mode write and a start pulse sampled together while idle are both accepted, and the burst uses the newly written settings.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| mrsValid | input | 1 | Mode write request |
| mrsAddr | input | 13 | Mode settings carried on the address bus |
| startValid | input | 1 | Begin a burst |
| startCol | input | 10 | First column address of the burst |
| beatValid | output | 1 | A beat-address pair is present |
| beatAddrRise | output | 10 | Column address of the rising-edge beat |
| beatAddrFall | output | 10 | Column address of the falling-edge beat |
| lastBeat | output | 1 | The current pair holds the final beat |
| burstDone | output | 1 | One-cycle pulse after the burst ends |
| busy | output | 1 | Burst in progress |
| mrsError | output | 1 | A mode write was refused in the previous cycle |
| cfgLatHalf | output | 3 | Stored CAS latency in half clocks (4 or 5) |

## Verification
Several properties are checked by assertions on every cycle. The done pulse lasts one cycle and always follows the last-beat flag. The settings hold steady for the whole of a burst. The pair counter never passes the final pair. Both beats of a pair sit in the same aligned block. Every error pulse traces back to a mode write one cycle earlier.

Other behaviour can only be shown by the bench scenarios. These cover the exact beat orders for each length and wrap type, including wrap at the top of the column space. They also cover the refusal of busy-time and malformed mode writes, starts that are ignored during a burst, back-to-back bursts started in the done cycle, and the simultaneous mode-write-and-start case.

// File: rtl/burst_col_pkg.sv
package burst_col_pkg;

  // Control-to-datapath strobes
  typedef struct packed {
    logic loadMode;   // capture new settings
    logic loadBase;   // capture start column, clear pair counter
    logic advance;    // step to the next beat pair
    logic inBurst;    // a burst is running
  } ctrlStrb_t;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_RUN  = 1'b1
  } burstState_t;

  // Latency codes in the mode word
  localparam logic [2:0] LAT_CODE_CL2  = 3'b010;
  localparam logic [2:0] LAT_CODE_CL25 = 3'b110;

endpackage

// File: rtl/burst_col_dp.sv
module burst_col_dp
  import burst_col_pkg::*;
#(
  parameter int COL_W  = 10,
  parameter int MODE_W = 13,
  parameter int MAX_BL = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrb_t         strb,
  input  logic [MODE_W-1:0] mrsAddr,
  input  logic [COL_W-1:0]  startCol,
  output logic              modeOk,
  output logic              lastPair,
  output logic [COL_W-1:0]  beatAddrRise,
  output logic [COL_W-1:0]  beatAddrFall,
  output logic [2:0]        cfgLatHalf
);

  localparam int BEAT_W = $clog2(MAX_BL);
  localparam int PAIR_W = (BEAT_W > 1) ? BEAT_W - 1 : 1;
  localparam int LG_W   = $clog2(BEAT_W + 1);

  // Settings
  logic [LG_W-1:0]   lenLog;
  logic              interleave;
  logic [2:0]        latHalf;
  logic [COL_W-1:0]  baseCol;
  logic [PAIR_W-1:0] pairIdx;

  // Decode of the incoming mode word
  logic [2:0]      lenField;
  logic [2:0]      latField;
  logic            lenOk;
  logic            latOk;
  logic [LG_W-1:0] newLenLog;
  logic [2:0]      newLatHalf;

  always_comb begin
    lenField   = mrsAddr[2:0];
    latField   = mrsAddr[6:4];
    lenOk      = 1'b0;
    newLenLog  = LG_W'(1);
    case (lenField)
      3'd1: begin lenOk = 1'b1; newLenLog = LG_W'(1); end
      3'd2: begin lenOk = (MAX_BL >= 4); newLenLog = LG_W'(2); end
      3'd3: begin lenOk = (MAX_BL >= 8); newLenLog = LG_W'(3); end
      default: begin lenOk = 1'b0; newLenLog = LG_W'(1); end
    endcase
    latOk      = 1'b1;
    newLatHalf = 3'd4;
    if (latField == LAT_CODE_CL2)       newLatHalf = 3'd4;
    else if (latField == LAT_CODE_CL25) newLatHalf = 3'd5;
    else                                latOk = 1'b0;
    modeOk = lenOk && latOk;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      lenLog     <= LG_W'(1);
      interleave <= 1'b0;
      latHalf    <= 3'd4;
    end else if (strb.loadMode) begin
      lenLog     <= newLenLog;
      interleave <= mrsAddr[3];
      latHalf    <= newLatHalf;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      baseCol <= '0;
      pairIdx <= '0;
    end else if (strb.loadBase) begin
      baseCol <= startCol;
      pairIdx <= '0;
    end else if (strb.advance) begin
      pairIdx <= pairIdx + PAIR_W'(1);
    end
  end

  // Final pair index is BL/2 - 1
  logic [PAIR_W-1:0] lastIdx;
  logic [COL_W-1:0]  wrapMask;

  always_comb begin
    lastIdx  = PAIR_W'(((1 << lenLog) >> 1) - 1);
    wrapMask = (COL_W'(1) << lenLog) - COL_W'(1);
    lastPair = (pairIdx == lastIdx);
  end

  function automatic logic [COL_W-1:0] orderBeat(
    input logic [COL_W-1:0] base,
    input logic [COL_W-1:0] mask,
    input logic [BEAT_W-1:0] n,
    input logic              il
  );
    logic [COL_W-1:0] nExt;
    nExt = COL_W'(n);
    if (il) orderBeat = base ^ (nExt & mask);
    else    orderBeat = (base & ~mask) | ((base + nExt) & mask);
  endfunction

  // One address lane per clock edge
  logic [COL_W-1:0] laneAddr [2];

  for (genvar e = 0; e < 2; e++) begin : g_lane
    logic [BEAT_W-1:0] beatNum;
    always_comb begin
      beatNum     = {pairIdx, 1'b0} | BEAT_W'(e);
      laneAddr[e] = orderBeat(baseCol, wrapMask, beatNum, interleave);
    end
  end

  assign beatAddrRise = laneAddr[0];
  assign beatAddrFall = laneAddr[1];
  assign cfgLatHalf   = latHalf;

  // R9
  cfg_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strb.inBurst && $past(strb.inBurst)) |-> ($stable(lenLog) && $stable(interleave) && $stable(latHalf)));

  // R3
  pair_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.inBurst |-> (pairIdx <= lastIdx));

  // R4
  same_block_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.inBurst |-> ((beatAddrRise & ~wrapMask) == (beatAddrFall & ~wrapMask)));

  // R2
  lat_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    (latHalf == 3'd4) || (latHalf == 3'd5));

endmodule

// File: rtl/burst_col_ctrl.sv
module burst_col_ctrl
  import burst_col_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      mrsValid,
  input  logic      startValid,
  input  logic      modeOk,
  input  logic      lastPair,
  output ctrlStrb_t strb,
  output logic      beatValid,
  output logic      lastBeat,
  output logic      burstDone,
  output logic      busy,
  output logic      mrsError
);

  burstState_t state;
  logic        idle;

  assign idle = (state == ST_IDLE);

  always_comb begin
    strb.loadMode = mrsValid && idle && modeOk;
    strb.loadBase = startValid && idle;
    strb.inBurst  = !idle;
    strb.advance  = !idle && !lastPair;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      burstDone <= 1'b0;
      mrsError  <= 1'b0;
    end else begin
      burstDone <= 1'b0;
      mrsError  <= mrsValid && (!idle || !modeOk);
      case (state)
        ST_IDLE: if (startValid) state <= ST_RUN;
        ST_RUN: if (lastPair) begin
          state     <= ST_IDLE;
          burstDone <= 1'b1;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign beatValid = !idle;
  assign busy      = !idle;
  assign lastBeat  = !idle && lastPair;

  // R7
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    burstDone |=> !burstDone);

  // R6
  last_then_done_chk: assert property (@(posedge clk) disable iff (!rstN)
    lastBeat |=> (burstDone && !beatValid));

  // R7
  done_after_last_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(burstDone) |-> $past(lastBeat));

  // R9
  err_cause_chk: assert property (@(posedge clk) disable iff (!rstN)
    mrsError |-> $past(mrsValid));

endmodule

// File: rtl/burst_col_gen.sv
module burst_col_gen
  import burst_col_pkg::*;
#(
  parameter int COL_W  = 10,
  parameter int MODE_W = 13,
  parameter int MAX_BL = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              mrsValid,
  input  logic [MODE_W-1:0] mrsAddr,
  input  logic              startValid,
  input  logic [COL_W-1:0]  startCol,
  output logic              beatValid,
  output logic [COL_W-1:0]  beatAddrRise,
  output logic [COL_W-1:0]  beatAddrFall,
  output logic              lastBeat,
  output logic              burstDone,
  output logic              busy,
  output logic              mrsError,
  output logic [2:0]        cfgLatHalf
);

  ctrlStrb_t strb;
  logic      modeOk;
  logic      lastPair;

  burst_col_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .mrsValid   (mrsValid),
    .startValid (startValid),
    .modeOk     (modeOk),
    .lastPair   (lastPair),
    .strb       (strb),
    .beatValid  (beatValid),
    .lastBeat   (lastBeat),
    .burstDone  (burstDone),
    .busy       (busy),
    .mrsError   (mrsError)
  );

  burst_col_dp #(
    .COL_W  (COL_W),
    .MODE_W (MODE_W),
    .MAX_BL (MAX_BL)
  ) u_dp (
    .clk          (clk),
    .rstN         (rstN),
    .strb         (strb),
    .mrsAddr      (mrsAddr),
    .startCol     (startCol),
    .modeOk       (modeOk),
    .lastPair     (lastPair),
    .beatAddrRise (beatAddrRise),
    .beatAddrFall (beatAddrFall),
    .cfgLatHalf   (cfgLatHalf)
  );

endmodule

// File: tb/test_burst_col_gen.sv
`timescale 1ns/1ps
module test_burst_col_gen;

  localparam real CLK_PERIOD = 4.0;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        mrsValid = 1'b0;
  logic [12:0] mrsAddr = '0;
  logic        startValid = 1'b0;
  logic [9:0]  startCol = '0;
  logic        beatValid, lastBeat, burstDone, busy, mrsError;
  logic [9:0]  beatAddrRise, beatAddrFall;
  logic [2:0]  cfgLatHalf;

  int nCmp = 0;
  int nBad = 0;
  bit finished = 0;

  // Reference settings
  int  mBl  = 2;
  bit  mIl  = 0;
  int  mLat = 4;

  always #(CLK_PERIOD/2) clk = ~clk;

  burst_col_gen i_burst_col_gen (
    .clk(clk), .rstN(rstN), .mrsValid(mrsValid), .mrsAddr(mrsAddr),
    .startValid(startValid), .startCol(startCol), .beatValid(beatValid),
    .beatAddrRise(beatAddrRise), .beatAddrFall(beatAddrFall),
    .lastBeat(lastBeat), .burstDone(burstDone), .busy(busy),
    .mrsError(mrsError), .cfgLatHalf(cfgLatHalf)
  );

  task automatic check(input string req, input int act, input int exp);
    nCmp++;
    if (act != exp) begin
      nBad++;
      $display("FAIL %s: actual %0d (0x%0h) expected %0d (0x%0h) at %0t", req, act, act, exp, exp, $time);
    end
  endtask

  function automatic int expBeat(input int base, input int n, input int bl, input bit il);
    int blk, off;
    blk = base - (base % bl);
    off = base % bl;
    if (il) return blk + (off ^ n);
    return blk + ((off + n) % bl);
  endfunction

  function automatic logic [12:0] modeWord(input int bl, input bit il, input int lat);
    logic [2:0] lc;
    lc = (bl == 2) ? 3'd1 : (bl == 4) ? 3'd2 : 3'd3;
    return {6'd0, (lat == 5) ? 3'b110 : 3'b010, il, lc};
  endfunction

  // Mode write while idle; ok says whether the code is supported
  task automatic doMrs(input logic [12:0] word, input bit ok, input int bl, input bit il, input int lat);
    @(negedge clk);
    mrsValid = 1'b1; mrsAddr = word;
    @(negedge clk);
    mrsValid = 1'b0;
    if (ok) begin mBl = bl; mIl = il; mLat = lat; end
    check(ok ? "R2 error flag" : "R10 error flag", int'(mrsError), ok ? 0 : 1);
    check(ok ? "R2 latency" : "R10 latency held", int'(cfgLatHalf), mLat);
  endtask

  // Run one burst; preDriven means start already sampled at the coming edge
  task automatic runBurst(input int col, input bit preDriven, input bit inj,
                          input bit chain, input int nextCol);
    bit prevMrs;
    if (!preDriven) begin
      @(negedge clk);
      startValid = 1'b1; startCol = 10'(col);
    end
    prevMrs = 0;
    for (int p = 0; p < mBl/2; p++) begin
      @(negedge clk);
      startValid = 1'b0; mrsValid = 1'b0;
      check("R9 busy error", int'(mrsError), int'(prevMrs));
      check("R3 valid", int'(beatValid), 1);
      check("R3 busy", int'(busy), 1);
      check(mIl ? "R5 rise beat" : "R4 rise beat", int'(beatAddrRise), expBeat(col, 2*p, mBl, mIl));
      check(mIl ? "R5 fall beat" : "R4 fall beat", int'(beatAddrFall), expBeat(col, 2*p+1, mBl, mIl));
      check("R6 last flag", int'(lastBeat), (p == mBl/2-1) ? 1 : 0);
      check("R7 no done", int'(burstDone), 0);
      check("R9 latency held", int'(cfgLatHalf), mLat);
      prevMrs = 0;
      if (inj) begin
        if ($urandom_range(0, 2) == 0) begin
          startValid = 1'b1; startCol = 10'($urandom);  // R8
        end
        if ($urandom_range(0, 2) == 0) begin
          mrsValid = 1'b1; mrsAddr = modeWord(8, 1, 5); // R9
          prevMrs = 1;
        end
      end
    end
    @(negedge clk);
    startValid = 1'b0; mrsValid = 1'b0;
    check("R9 busy error", int'(mrsError), int'(prevMrs));
    check("R7 done", int'(burstDone), 1);
    check("R7 valid low", int'(beatValid), 0);
    check("R7 busy low", int'(busy), 0);
    check("R9 latency held", int'(cfgLatHalf), mLat);
    if (chain) begin
      startValid = 1'b1; startCol = 10'(nextCol);
    end else begin
      @(negedge clk);
      check("R7 done one cycle", int'(burstDone), 0);
      check("R8 stays idle", int'(beatValid), 0);
    end
  endtask

  initial begin
    void'($urandom(32'h5EED_1234));
    repeat (3) @(negedge clk);
    check("R1 valid", int'(beatValid), 0);
    check("R1 busy", int'(busy), 0);
    check("R1 done", int'(burstDone), 0);
    check("R1 last", int'(lastBeat), 0);
    check("R1 error", int'(mrsError), 0);
    rstN = 1'b1;
    @(negedge clk);
    check("R1 latency", int'(cfgLatHalf), 4);
    runBurst(10'h0F3, 0, 0, 0, 0);               // R1 default BL2 sequential

    doMrs(modeWord(8, 0, 4), 1, 8, 0, 4);         // R2
    runBurst(10'h005, 0, 0, 0, 0);               // R4 mid-block start
    doMrs(modeWord(8, 1, 5), 1, 8, 1, 5);
    runBurst(10'h3FE, 0, 0, 0, 0);               // R5
    doMrs(modeWord(4, 0, 5), 1, 4, 0, 5);
    runBurst(10'h3FF, 0, 0, 0, 0);               // R4 wrap at top

    doMrs(13'h0020, 0, 0, 0, 0);                 // R10 length code 0
    doMrs(13'h0027, 0, 0, 0, 0);                 // R10 length code 7
    doMrs(13'h0032, 0, 0, 0, 0);                 // R10 latency code 3
    runBurst(10'h102, 0, 0, 0, 0);               // R10 settings unchanged

    // R7 back-to-back: start driven in the done cycle
    runBurst(10'h011, 0, 0, 1, 10'h2A6);
    runBurst(10'h2A6, 1, 0, 0, 0);

    // R11 mode write and start together
    @(negedge clk);
    mrsValid = 1'b1; mrsAddr = modeWord(8, 1, 4);
    startValid = 1'b1; startCol = 10'h15B;
    mBl = 8; mIl = 1; mLat = 4;
    runBurst(10'h15B, 1, 0, 0, 0);

    // Random settings and starts with busy-time injections (R8, R9)
    for (int i = 0; i < 60; i++) begin
      int bl, lat; bit il;
      bl  = 2 << $urandom_range(0, 2);
      il  = 1'($urandom_range(0, 1));
      lat = $urandom_range(4, 5);
      doMrs(modeWord(bl, il, lat), 1, bl, il, lat);
      runBurst(int'(10'($urandom)), 0, 1, 0, 0);
    end

    if (!finished) begin
      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      nCmp++; nBad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
      $finish;
    end
  end

endmodule